// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI function's configuration header. Six of its bits are sticky event flags. Each flag latches a single-cycle strobe from the bus master or bus target state machines: a detected parity error, an asserted system error, an issued master abort, a received target abort, a signaled target abort, and a master data parity error. The remaining bits return fixed capability values. Two independent write paths can clear flags with write-one-to-clear semantics, qualified by byte enables. One path comes from the on-chip bus and one from PCI configuration space.

The master data parity error flag has its own qualifier. It latches only when three things are true in the same cycle. The first is a parity error condition: PERR was driven on a read or observed on a write. The second is that this agent mastered the failing transfer. The third is that parity-error response is enabled in the command register. A host-mode select stops every flag from being set. Clearing still works in host mode.

Top module: `pci_cfg_status_reg`

## Requirements
- R1: While the synchronous active-low reset is low, and on the first cycle after it, `status_q` reads 16'h0210 and all flags are 0.
- R2: A one-cycle strobe sets the corresponding flag, which is visible on `status_q` after the next rising edge. The mapping is: `parity_err_evt` to bit 15, `serr_drive_evt` to bit 14, `mst_abort_evt` to bit 13, `mst_tabort_rcv_evt` to bit 12, and `tgt_abort_sig_evt` to bit 11.
- R3: Bit 8 sets only in a cycle where `perr_resp_en`, `was_bus_master` and at least one of `perr_drove_rd` or `perr_seen_wr` are all 1.
- R4: While `host_mode` is 1, no flag can be set by any event. Clearing keeps working.
- R5: A write on the internal port (`ib_wr_en`=1) clears each flag whose data bit is 1 within an enabled byte. Data bits that are 0 leave flags unchanged.
- R6: A write on the PCI port (`pc_wr_en`=1) clears flags with the same rules as R5.
- R7: Byte enable bit 0 covers status bits 7:0 and byte enable bit 1 covers bits 15:8. A write whose byte enable bit 1 is 0 changes no flag.
- R8: When both ports write in the same cycle, the flags cleared are the union of the two clear masks.
- R9: If a flag's event and a clear of that flag occur in the same cycle, the flag ends up set.
- R10: Bits 10:9 always read 01 and bit 4 always reads 1. Bits 7, 6, 5 and 3:0 always read 0. No write on either port changes these bits.
- R11: With no event and no clear, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode | input | 1 | 1 = suppress all flag setting |
| perr_resp_en | input | 1 | Parity-error response enable from the command register |
| parity_err_evt | input | 1 | Strobe: parity error detected |
| serr_drive_evt | input | 1 | Strobe: this controller drove SERR |
| mst_abort_evt | input | 1 | Strobe: master abort issued as master |
| mst_tabort_rcv_evt | input | 1 | Strobe: target abort received as master |
| tgt_abort_sig_evt | input | 1 | Strobe: target abort signaled as target |
| perr_drove_rd | input | 1 | This agent drove PERR during a read |
| perr_seen_wr | input | 1 | This agent observed PERR during a write |
| was_bus_master | input | 1 | This agent mastered the failing transfer |
| ib_wr_en | input | 1 | Internal-bus write strobe |
| ib_wr_be | input | 2 | Internal-bus byte enables |
| ib_wr_data | input | 16 | Internal-bus write data (1 = clear) |
| pc_wr_en | input | 1 | PCI configuration write strobe |
| pc_wr_be | input | 2 | PCI configuration byte enables |
| pc_wr_data | input | 16 | PCI configuration write data (1 = clear) |
| status_q | output | 16 | Current status word |

## Verification
The bench builds the block with its default parameters: a 16-bit word, two byte lanes and two write ports. At that size, every combination of the five inputs that gate the master data parity error flag is swept, as is every byte-enable pattern on both ports. A long pseudo-random run compares the output each cycle against an arithmetic model of set, clear and host-mode suppression. This run also covers collisions of events with clears from one or both ports.

// File: rtl/pcs_pkg.sv
// Package: shared constants and the flag-to-bit map of the status word.
// Assumes a 16-bit status word split into two byte lanes.
package pcs_pkg;

    localparam int unsigned NUM_FLAGS = 6;
    localparam int unsigned LANE_W    = 8;

    // Fixed read value: bits 10:9 = 01 (medium decode), bit 4 = 1 (capabilities list).
    localparam logic [15:0] FIXED_VAL = 16'h0210;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    // Flag index to status bit position; the order of indices is the project's own.
    function automatic int unsigned flag_pos(input int unsigned idx);
        case (idx)
            0:       return 8;   // master data parity error
            1:       return 11;  // target abort signaled
            2:       return 12;  // target abort received
            3:       return 13;  // master abort issued
            4:       return 14;  // system error driven
            default: return 15;  // parity error detected
        endcase
    endfunction

endpackage

// File: rtl/pcs_mdpe_qual.sv
// Module: qualifies the master data parity error event.
// Assumes all inputs are sampled in the same cycle as the failing data phase.
module pcs_mdpe_qual (
    input  logic perr_drove_rd,
    input  logic perr_seen_wr,
    input  logic was_bus_master,
    input  logic perr_resp_en,
    output logic mdpe_evt
);

    // Purpose: raise the event only when the error, mastership and enable coincide.
    always_comb begin
        mdpe_evt = (perr_drove_rd | perr_seen_wr) & was_bus_master & perr_resp_en;
    end

endmodule

// File: rtl/pcs_clear_merge.sv
// Module: turns the byte-enabled write-one-to-clear writes of several ports
// into one clear vector per flag, ORing the ports together.
// Assumes STAT_W is a multiple of the lane width.
module pcs_clear_merge
    import pcs_pkg::*;
#(
    parameter int unsigned STAT_W    = 16,
    parameter int unsigned NUM_PORTS = 2,
    localparam int unsigned BE_W     = STAT_W / LANE_W
) (
    input  logic [NUM_PORTS-1:0]        wr_en,
    input  logic [NUM_PORTS*BE_W-1:0]   wr_be,
    input  logic [NUM_PORTS*STAT_W-1:0] wr_data,
    output flag_vec_t                   clr_vec
);

    logic [NUM_PORTS-1:0][NUM_FLAGS-1:0] port_clr;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
            localparam int unsigned POS  = flag_pos(f);
            localparam int unsigned LANE = POS / LANE_W;
            // Purpose: this port clears flag f when its lane is enabled and the data bit is 1.
            always_comb begin
                port_clr[p][f] = wr_en[p] & wr_be[p*BE_W + LANE] & wr_data[p*STAT_W + POS];
            end
        end
    end

    // Purpose: union of all ports' clear requests.
    always_comb begin
        clr_vec = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            clr_vec = clr_vec | port_clr[p];
        end
    end

endmodule

// File: rtl/pcs_flag_bank.sv
// Module: the sticky event flags. A set beats a clear in the same cycle, and
// host mode blocks every set.
// Assumes set and clear vectors are valid one cycle before the edge that samples them.
module pcs_flag_bank
    import pcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      host_mode,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_vec,
    output flag_vec_t flags_q
);

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        // Purpose: hold one flag; reset, then clear, then qualified set on top.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[f] <= 1'b0;
            end else begin
                flags_q[f] <= (flags_q[f] & ~clr_vec[f]) | (set_vec[f] & ~host_mode);
            end
        end

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[f] && !host_mode) |=> flags_q[f]);

        // R4
        host_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (host_mode && !flags_q[f]) |=> !flags_q[f]);

        // R5
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[f] && !(set_vec[f] && !host_mode)) |=> !flags_q[f]);

        // R11
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_vec[f] && !clr_vec[f]) |=> $stable(flags_q[f]));
    end

endmodule

// File: rtl/pci_cfg_status_reg.sv
// Module: PCI configuration status word. Collects event strobes into sticky
// flags, merges two write-one-to-clear ports, and overlays the fixed fields.
// Assumes single-cycle strobes and a synchronous active-low reset.
module pci_cfg_status_reg
    import pcs_pkg::*;
#(
    parameter int unsigned STAT_W = 16,
    localparam int unsigned BE_W  = STAT_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode,
    input  logic              perr_resp_en,
    input  logic              parity_err_evt,
    input  logic              serr_drive_evt,
    input  logic              mst_abort_evt,
    input  logic              mst_tabort_rcv_evt,
    input  logic              tgt_abort_sig_evt,
    input  logic              perr_drove_rd,
    input  logic              perr_seen_wr,
    input  logic              was_bus_master,
    input  logic              ib_wr_en,
    input  logic [BE_W-1:0]   ib_wr_be,
    input  logic [STAT_W-1:0] ib_wr_data,
    input  logic              pc_wr_en,
    input  logic [BE_W-1:0]   pc_wr_be,
    input  logic [STAT_W-1:0] pc_wr_data,
    output logic [STAT_W-1:0] status_q
);

    logic      mdpe_evt;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flags_q;

    pcs_mdpe_qual u_mdpe (
        .perr_drove_rd  (perr_drove_rd),
        .perr_seen_wr   (perr_seen_wr),
        .was_bus_master (was_bus_master),
        .perr_resp_en   (perr_resp_en),
        .mdpe_evt       (mdpe_evt)
    );

    // Purpose: order the event strobes by flag index.
    always_comb begin
        set_vec = {parity_err_evt, serr_drive_evt, mst_abort_evt,
                   mst_tabort_rcv_evt, tgt_abort_sig_evt, mdpe_evt};
    end

    pcs_clear_merge #(
        .STAT_W    (STAT_W),
        .NUM_PORTS (2)
    ) u_clr (
        .wr_en   ({pc_wr_en, ib_wr_en}),
        .wr_be   ({pc_wr_be, ib_wr_be}),
        .wr_data ({pc_wr_data, ib_wr_data}),
        .clr_vec (clr_vec)
    );

    pcs_flag_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_mode (host_mode),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .flags_q   (flags_q)
    );

    // Purpose: place the flags over the fixed capability fields.
    always_comb begin
        status_q = STAT_W'(FIXED_VAL);
        for (int unsigned f = 0; f < NUM_FLAGS; f++) begin
            status_q[flag_pos(f)] = flags_q[f];
        end
    end

    // R10
    fixed_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[10:9] == 2'b01) && status_q[4] && (status_q[7:5] == 3'b000)
        && (status_q[3:0] == 4'h0));

    // R3
    mdpe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[8]) |-> $past(perr_resp_en && was_bus_master && !host_mode
                                     && (perr_drove_rd || perr_seen_wr)));

endmodule

// File: tb/pci_cfg_status_reg_bench.sv
module pci_cfg_status_reg_bench;

    localparam logic [15:0] FIXED = 16'h0210;
    localparam logic [15:0] FMASK = 16'hF900;

    logic        clk = 1'b0;
    logic        rst_n, host_mode, perr_resp_en;
    logic        parity_err_evt, serr_drive_evt, mst_abort_evt;
    logic        mst_tabort_rcv_evt, tgt_abort_sig_evt;
    logic        perr_drove_rd, perr_seen_wr, was_bus_master;
    logic        ib_wr_en, pc_wr_en;
    logic [1:0]  ib_wr_be, pc_wr_be;
    logic [15:0] ib_wr_data, pc_wr_data;
    logic [15:0] status_q;

    int          total = 0;
    int          bad   = 0;
    logic [15:0] exp_flags = 16'h0;

    always #10 clk = ~clk;

    pci_cfg_status_reg u_pci_cfg_status_reg (.*);

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        {parity_err_evt, serr_drive_evt, mst_abort_evt, mst_tabort_rcv_evt,
         tgt_abort_sig_evt, perr_drove_rd, perr_seen_wr, was_bus_master} = '0;
        ib_wr_en = 0; pc_wr_en = 0; ib_wr_be = 0; pc_wr_be = 0;
        ib_wr_data = 0; pc_wr_data = 0;
    endtask

    // One clock: model the edge from the driven inputs, compare, then drop strobes.
    task automatic step(input string tag);
        logic [15:0] setv, clr;
        @(posedge clk);
        setv = {parity_err_evt, serr_drive_evt, mst_abort_evt, mst_tabort_rcv_evt,
                tgt_abort_sig_evt, 2'b00,
                (perr_drove_rd | perr_seen_wr) & was_bus_master & perr_resp_en, 8'h00};
        clr = 16'h0;
        if (ib_wr_en) clr |= ib_wr_data & {{8{ib_wr_be[1]}}, {8{ib_wr_be[0]}}};
        if (pc_wr_en) clr |= pc_wr_data & {{8{pc_wr_be[1]}}, {8{pc_wr_be[0]}}};
        if (!rst_n) exp_flags = 16'h0;
        else exp_flags = (exp_flags & ~(clr & FMASK)) | (host_mode ? 16'h0 : setv);
        @(negedge clk);
        check(tag, status_q, exp_flags | FIXED);
        quiet();
    endtask

    task automatic fire_all();
        {parity_err_evt, serr_drive_evt, mst_abort_evt, mst_tabort_rcv_evt,
         tgt_abort_sig_evt} = 5'h1F;
        perr_seen_wr = 1; was_bus_master = 1;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] lfsr;
        quiet();
        rst_n = 0; host_mode = 0; perr_resp_en = 1;
        @(negedge clk);
        // R1: reset value
        fire_all(); step("R1");
        step("R1");
        rst_n = 1;
        step("R1");

        // R2: each event alone, then clear from the internal port
        for (int k = 0; k < 5; k++) begin
            {parity_err_evt, serr_drive_evt, mst_abort_evt, mst_tabort_rcv_evt,
             tgt_abort_sig_evt} = 5'(1 << k);
            step("R2");
            step("R11");
            ib_wr_en = 1; ib_wr_be = 2'b11; ib_wr_data = 16'hFFFF; step("R5");
        end

        // R3 / R4: sweep all qualifier and host combinations, clear from PCI port
        for (int c = 0; c < 32; c++) begin
            {host_mode, perr_drove_rd, perr_seen_wr, was_bus_master, perr_resp_en} = 5'(c);
            step(host_mode ? "R4" : "R3");
            pc_wr_en = 1; pc_wr_be = 2'b11; pc_wr_data = 16'hFFFF; step("R6");
        end
        host_mode = 0; perr_resp_en = 1;

        // R4: host mode blocks every event, still clears
        fire_all(); step("R2");
        host_mode = 1; fire_all(); ib_wr_en = 1; ib_wr_be = 2'b10; ib_wr_data = 16'h0800;
        step("R4");
        fire_all(); step("R4");
        host_mode = 0;

        // R7 / R10: all byte-enable patterns on both ports with all-ones data
        for (int b = 0; b < 4; b++) begin
            fire_all(); step("R2");
            ib_wr_en = 1; ib_wr_be = 2'(b); ib_wr_data = 16'hFFFF; step("R7");
            fire_all(); step("R2");
            pc_wr_en = 1; pc_wr_be = 2'(b); pc_wr_data = 16'hFFFF; step("R10");
        end

        // R5: zero data bits leave flags alone
        fire_all(); step("R2");
        ib_wr_en = 1; ib_wr_be = 2'b11; ib_wr_data = 16'h0000; step("R5");
        ib_wr_en = 1; ib_wr_be = 2'b11; ib_wr_data = 16'h2100; step("R5");

        // R8: both ports together
        fire_all(); step("R2");
        ib_wr_en = 1; ib_wr_be = 2'b10; ib_wr_data = 16'h8800;
        pc_wr_en = 1; pc_wr_be = 2'b10; pc_wr_data = 16'h4100; step("R8");

        // R9: set and clear on same bit
        mst_abort_evt = 1; ib_wr_en = 1; ib_wr_be = 2'b11; ib_wr_data = 16'hFFFF; step("R9");
        mst_abort_evt = 1; pc_wr_en = 1; pc_wr_be = 2'b10; pc_wr_data = 16'h2000; step("R9");

        // R11: pseudo-random run against the model
        lfsr = 32'hACE1_2345;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            {parity_err_evt, serr_drive_evt, mst_abort_evt, mst_tabort_rcv_evt,
             tgt_abort_sig_evt} = lfsr[4:0] & lfsr[9:5];
            {perr_drove_rd, perr_seen_wr, was_bus_master, perr_resp_en} = lfsr[13:10];
            host_mode  = lfsr[14] & lfsr[15] & lfsr[16];
            ib_wr_en   = lfsr[17] & lfsr[18];
            ib_wr_be   = lfsr[20:19];
            ib_wr_data = {lfsr[31:24], lfsr[7:0]};
            pc_wr_en   = lfsr[21] & lfsr[22];
            pc_wr_be   = lfsr[24:23];
            pc_wr_data = {lfsr[15:8], lfsr[31:24]};
            step("R11");
        end
        summary();
    end

endmodule